// File: doc/BRIEF.md
# DRAM strobe cycle classifier

This block sits on the device side of an asynchronous DRAM strobe interface. It takes the row strobe, column strobe, write enable and output enable as active-low levels, already synchronised to the block clock. From them it works out what kind of memory cycle is taking place. The classification comes from the order in which the strobe edges arrive, not from the levels alone. Column-before-row gives an internal refresh, and its write-enable level picks normal refresh or the test-mode variant. A column strobe still held low from the previous access turns the next row strobe into a hidden refresh. Whether write enable falls before or after the column strobe separates an early write from a late write.

Alongside the classification, the block keeps the internal refresh row counter and the test-mode flag. It reports the row each refresh cycle acts on, and decides when the data pins may be driven. It can serve as a protocol checker on a memory bus, or as the control half of a behavioural DRAM model. All outputs are registered and change on the clock edge that samples the strobe edge responsible.

Top module: `dram_cyc_classifier`

## Requirements
- R1: While reset is asserted, and just after it is released, the outputs are: cycle code 0 (idle), refresh counter 0, test mode 0, error 0, data-pin enable 0, refresh-valid 0 and write-capture 0.
- R2: A row strobe fall with the column strobe high gives code 1 (row open). A following column strobe fall gives code 2 (read) if write enable is high, or code 3 (early write) if write enable is low; an early write pulses write-capture.
- R3: Write enable falling while both strobes are low, in a read (code 2), gives code 4 (late write), pulses write-capture and raises the late-write flag.
- R4: A row strobe rise while the code is 1 gives code 5 (row-only refresh) and pulses refresh-valid, with the refresh row equal to the address sampled at the row strobe fall.
- R5: A column strobe fall while the row strobe is high, followed later by a row strobe fall, gives code 6 if write enable is high at that fall or code 7 (test-mode refresh) if it is low. The refresh row is the counter value, and the counter then increments by one.
- R6: A row strobe fall while the column strobe is still low from an earlier access, with no column fall since the row strobe rose, gives code 8 (hidden refresh). It uses and increments the counter.
- R7: The refresh counter is ROW_W bits wide; after the value 2^ROW_W-1 the next refresh uses that value and leaves the counter at 0.
- R8: Code 7 sets test mode. Code 6 or code 5 clears it. A hidden refresh leaves it unchanged.
- R9: The data pins are enabled only while read data is valid, output enable is low and the column strobe is low. Read data becomes valid on a read and is invalidated by a column strobe rise; an early write never validates it. It is retained through a late write and through a hidden refresh.
- R10: Row and column strobes falling in the same sample, or a column strobe fall while the row strobe is low in codes 6, 7 or 8, give code 9 (illegal) and set an error flag that stays set until reset.
- R11: With the row strobe held low, each further column strobe pulse classifies a new column access (read or early write) from the write-enable level at its fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ROW_W | Multiplexed address lines |
| cyc_type_o | output | 4 | Cycle classification code |
| wr_cap_o | output | 1 | One-cycle pulse when write data is captured |
| wr_late_o | output | 1 | Current cycle is a late write |
| dq_oe_o | output | 1 | Data pins may be driven |
| ref_row_o | output | ROW_W | Row of the latest refresh |
| ref_vld_o | output | 1 | One-cycle pulse marking a refresh |
| test_mode_o | output | 1 | Test mode active |
| err_o | output | 1 | Sticky illegal-sequence flag |

## Verification
The bench concentrates on edge order. It covers a hidden refresh taken straight after a read, which a level-only decoder would call a plain column-before-row refresh, wrongly changing test mode and dropping the held read data. It covers a late write, where a wrong design would tristate the pins or fail to capture, and page-mode column pulses that alternate read and early write. It also runs the counter through its full wrap, where an off-by-one would repeat or skip row 0. The sticky error is checked after legal cycles that follow both kinds of illegal sequence.

// File: rtl/dram_cc_pkg.sv
package dram_cc_pkg;
  typedef enum logic [3:0] {
    CT_IDLE    = 4'd0,
    CT_ROW     = 4'd1,
    CT_READ    = 4'd2,
    CT_EWR     = 4'd3,
    CT_LWR     = 4'd4,
    CT_RONLY   = 4'd5,
    CT_CBR     = 4'd6,
    CT_WCBR    = 4'd7,
    CT_HIDDEN  = 4'd8,
    CT_ILLEGAL = 4'd9
  } cyc_t;

  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic cas_rise;
    logic we_fall;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
  import dram_cc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  output strobe_ev_t ev_o,
  output logic       cas_q_o,
  output logic       oe_q_o
);
  logic ras_q, cas_q, we_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      we_q  <= we_ni;
      oe_q  <= oe_ni;
    end
  end

  always_comb begin
    ev_o.ras_fall = ras_q & ~ras_ni;
    ev_o.ras_rise = ~ras_q & ras_ni;
    ev_o.cas_fall = cas_q & ~cas_ni;
    ev_o.cas_rise = ~cas_q & cas_ni;
    ev_o.we_fall  = we_q & ~we_ni;
  end

  assign cas_q_o = cas_q;
  assign oe_q_o  = oe_q;
endmodule

// File: rtl/cycle_decoder.sv
module cycle_decoder
  import dram_cc_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobe_ev_t       ev_i,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [ROW_W-1:0] addr_i,
  output cyc_t             type_o,
  output logic             rd_vld_o,
  output logic             wr_cap_o,
  output logic             cnt_ref_o,
  output logic             ronly_o,
  output logic             tm_set_o,
  output logic             tm_clr_o,
  output logic [ROW_W-1:0] row_o,
  output logic             err_o
);
  cyc_t             type_q, type_d;
  logic             arm_q, arm_d;
  logic             vld_q, vld_d;
  logic             wcap_d, ill_d;
  logic             err_q;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    type_d    = type_q;
    arm_d     = arm_q;
    vld_d     = vld_q;
    wcap_d    = 1'b0;
    ill_d     = 1'b0;
    cnt_ref_o = 1'b0;
    ronly_o   = 1'b0;
    tm_set_o  = 1'b0;
    tm_clr_o  = 1'b0;

    if (ev_i.cas_rise) begin
      arm_d = 1'b0;
      vld_d = 1'b0;
    end
    // column fall with row idle arms a column-before-row refresh
    if (ev_i.cas_fall && ras_ni) arm_d = 1'b1;

    if (ev_i.ras_fall && ev_i.cas_fall) begin
      type_d = CT_ILLEGAL;
      ill_d  = 1'b1;
    end else if (ev_i.ras_fall && !cas_ni) begin
      cnt_ref_o = 1'b1;
      if (arm_q) begin
        arm_d = 1'b0;
        if (we_ni) begin
          type_d   = CT_CBR;
          tm_clr_o = 1'b1;
        end else begin
          type_d   = CT_WCBR;
          tm_set_o = 1'b1;
        end
      end else begin
        type_d = CT_HIDDEN;
      end
    end else if (ev_i.ras_fall) begin
      type_d = CT_ROW;
    end else if (ev_i.ras_rise && type_q == CT_ROW) begin
      type_d   = CT_RONLY;
      ronly_o  = 1'b1;
      tm_clr_o = 1'b1;
    end else if (ev_i.cas_fall && !ras_ni) begin
      case (type_q)
        CT_ROW, CT_READ, CT_EWR, CT_LWR: begin
          if (!we_ni) begin
            type_d = CT_EWR;
            wcap_d = 1'b1;
            vld_d  = 1'b0;
          end else begin
            type_d = CT_READ;
            vld_d  = 1'b1;
          end
        end
        CT_CBR, CT_WCBR, CT_HIDDEN: begin
          type_d = CT_ILLEGAL;
          ill_d  = 1'b1;
        end
        default: ;
      endcase
    end else if (ev_i.we_fall && !cas_ni && !ras_ni && type_q == CT_READ) begin
      type_d = CT_LWR;
      wcap_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q   <= CT_IDLE;
      arm_q    <= 1'b0;
      vld_q    <= 1'b0;
      wr_cap_o <= 1'b0;
      err_q    <= 1'b0;
      row_q    <= '0;
    end else begin
      type_q   <= type_d;
      arm_q    <= arm_d;
      vld_q    <= vld_d;
      wr_cap_o <= wcap_d;
      err_q    <= err_q | ill_d;
      if (ev_i.ras_fall) row_q <= addr_i;
    end
  end

  assign type_o   = type_q;
  assign rd_vld_o = vld_q;
  assign row_o    = row_q;
  assign err_o    = err_q;

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_wrcap_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cap_o |-> (type_q == CT_EWR || type_q == CT_LWR));
endmodule

// File: rtl/refresh_ctl.sv
module refresh_ctl #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_ref_i,
  input  logic             ronly_i,
  input  logic             tm_set_i,
  input  logic             tm_clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ref_vld_o,
  output logic             tm_o
);
  logic [ROW_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ref_row_o <= '0;
      ref_vld_o <= 1'b0;
      tm_o      <= 1'b0;
    end else begin
      ref_vld_o <= cnt_ref_i | ronly_i;
      if (cnt_ref_i) begin
        ref_row_o <= cnt_q;
        cnt_q     <= cnt_q + 1'b1;
      end else if (ronly_i) begin
        ref_row_o <= row_i;
      end
      if (tm_set_i)      tm_o <= 1'b1;
      else if (tm_clr_i) tm_o <= 1'b0;
    end
  end

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ref_i |=> (cnt_q == $past(cnt_q) + 1'b1) && (ref_row_o == $past(cnt_q)));
  p_tm_wcbr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tm_set_i |=> tm_o);
endmodule

// File: rtl/dram_cyc_classifier.sv
module dram_cyc_classifier
  import dram_cc_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [ROW_W-1:0] addr_i,
  output logic [3:0]       cyc_type_o,
  output logic             wr_cap_o,
  output logic             wr_late_o,
  output logic             dq_oe_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ref_vld_o,
  output logic             test_mode_o,
  output logic             err_o
);
  strobe_ev_t       ev;
  logic             cas_q, oe_q;
  cyc_t             cyc;
  logic             rd_vld, cnt_ref, ronly, tm_set, tm_clr;
  logic [ROW_W-1:0] row;

  strobe_sampler u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ras_ni  (ras_ni),
    .cas_ni  (cas_ni),
    .we_ni   (we_ni),
    .oe_ni   (oe_ni),
    .ev_o    (ev),
    .cas_q_o (cas_q),
    .oe_q_o  (oe_q)
  );

  cycle_decoder #(.ROW_W(ROW_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .addr_i    (addr_i),
    .type_o    (cyc),
    .rd_vld_o  (rd_vld),
    .wr_cap_o  (wr_cap_o),
    .cnt_ref_o (cnt_ref),
    .ronly_o   (ronly),
    .tm_set_o  (tm_set),
    .tm_clr_o  (tm_clr),
    .row_o     (row),
    .err_o     (err_o)
  );

  refresh_ctl #(.ROW_W(ROW_W)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_ref_i (cnt_ref),
    .ronly_i   (ronly),
    .tm_set_i  (tm_set),
    .tm_clr_i  (tm_clr),
    .row_i     (row),
    .ref_row_o (ref_row_o),
    .ref_vld_o (ref_vld_o),
    .tm_o      (test_mode_o)
  );

  assign cyc_type_o = cyc;
  assign wr_late_o  = (cyc == CT_LWR);
  assign dq_oe_o    = rd_vld & ~oe_q & ~cas_q;

  p_dq_off_cas_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_ni |=> !dq_oe_o);
  p_ewr_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_type_o == 4'd3) |-> !dq_oe_o);
  p_hidden_keeps_tm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_vld_o && cyc_type_o == 4'd8) |-> (test_mode_o == $past(test_mode_o)));
endmodule

// File: tb/sim_dram_cyc_classifier.sv
module sim_dram_cyc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 10;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ROW_W-1:0] addr = '0;
  logic [3:0] cyc_type;
  logic wr_cap, wr_late, dq_oe, ref_vld, tmode, err;
  logic [ROW_W-1:0] ref_row;

  int n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cyc_classifier #(.ROW_W(ROW_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr),
    .cyc_type_o(cyc_type), .wr_cap_o(wr_cap), .wr_late_o(wr_late),
    .dq_oe_o(dq_oe), .ref_row_o(ref_row), .ref_vld_o(ref_vld),
    .test_mode_o(tmode), .err_o(err)
  );

  // reference model
  int m_type = 0, m_cnt = 0, m_ref_row = 0, m_row = 0;
  bit m_arm = 0, m_vld = 0, m_tm = 0, m_err = 0, m_rv = 0, m_wc = 0;
  bit p_ras = 1, p_cas = 1, p_we = 1, p_oe = 1;

  task automatic chk(string req, int act, int exp, string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_type = 0; m_cnt = 0; m_ref_row = 0; m_row = 0;
      m_arm = 0; m_vld = 0; m_tm = 0; m_err = 0; m_rv = 0; m_wc = 0;
      p_ras = 1; p_cas = 1; p_we = 1; p_oe = 1;
    end else begin
      bit rf, rr, cf, cr, wf;
      rf = p_ras && !ras_n; rr = !p_ras && ras_n;
      cf = p_cas && !cas_n; cr = !p_cas && cas_n;
      wf = p_we && !we_n;
      m_wc = 0; m_rv = 0;
      if (cr) begin m_arm = 0; m_vld = 0; end
      if (cf && ras_n) m_arm = 1;
      if (rf && cf) begin m_type = 9; m_err = 1; end
      else if (rf && !cas_n) begin
        if (m_arm) begin m_type = we_n ? 6 : 7; m_tm = !we_n; m_arm = 0; end
        else m_type = 8;
        m_ref_row = m_cnt; m_rv = 1; m_cnt = (m_cnt + 1) % NROWS;
      end
      else if (rf) begin m_type = 1; m_row = int'(addr); end
      else if (rr && m_type == 1) begin m_type = 5; m_ref_row = m_row; m_rv = 1; m_tm = 0; end
      else if (cf && !ras_n) begin
        if (m_type >= 1 && m_type <= 4) begin
          if (!we_n) begin m_type = 3; m_wc = 1; m_vld = 0; end
          else begin m_type = 2; m_vld = 1; end
        end else if (m_type >= 6 && m_type <= 8) begin m_type = 9; m_err = 1; end
      end
      else if (wf && !cas_n && !ras_n && m_type == 2) begin m_type = 4; m_wc = 1; end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
    end
    #2;
    if (rst_n) begin
      chk(cur_req, int'(cyc_type), m_type, "cycle code");
      chk(cur_req, int'(wr_cap), int'(m_wc), "write capture");
      chk(cur_req, int'(wr_late), int'(m_type == 4), "late flag");
      chk(cur_req, int'(dq_oe), int'(m_vld && !p_oe && !p_cas), "pin enable");
      chk(cur_req, int'(ref_vld), int'(m_rv), "refresh valid");
      chk(cur_req, int'(ref_row), m_ref_row, "refresh row");
      chk(cur_req, int'(tmode), int'(m_tm), "test mode");
      chk(cur_req, int'(err), int'(m_err), "error");
    end
  end

  task automatic st(input logic r, input logic c, input logic w, input logic o);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    @(negedge clk);
  endtask

  task automatic cbr(input logic w);
    st(1, 0, w, 1); st(0, 0, w, 1); st(0, 0, 1, 1); st(1, 0, 1, 1); st(1, 1, 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(cyc_type), 0, "code in reset");
    chk("R1", int'(dq_oe), 0, "pins in reset");
    chk("R1", int'(tmode) + int'(err) + int'(ref_vld) + int'(wr_cap), 0, "flags in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(ref_row), 0, "row after reset");

    cur_req = "R2 R9 read";
    addr = 10'd5;
    st(0, 1, 1, 0);
    chk("R2", int'(cyc_type), 1, "row open");
    st(0, 0, 1, 0);
    chk("R2", int'(cyc_type), 2, "read");
    chk("R9", int'(dq_oe), 1, "read drives");
    st(0, 0, 1, 1);
    chk("R9", int'(dq_oe), 0, "oe high tristates");
    st(0, 0, 1, 0); st(0, 1, 1, 0);
    chk("R9", int'(dq_oe), 0, "cas high tristates");
    st(1, 1, 1, 1); st(1, 1, 1, 1);

    cur_req = "R2 R9 early write";
    st(0, 1, 0, 0); st(0, 0, 0, 0);
    chk("R2", int'(cyc_type), 3, "early write");
    chk("R9", int'(dq_oe), 0, "early write quiet");
    st(0, 0, 1, 0);
    chk("R9", int'(dq_oe), 0, "early write stays quiet");
    st(0, 1, 1, 0); st(1, 1, 1, 1);

    cur_req = "R3 R9 late write";
    st(0, 1, 1, 0); st(0, 0, 1, 0); st(0, 0, 0, 0);
    chk("R3", int'(cyc_type), 4, "late write");
    chk("R3", int'(wr_late), 1, "late flag");
    chk("R9", int'(dq_oe), 1, "late write keeps data");
    st(0, 0, 0, 1); st(0, 1, 1, 1); st(1, 1, 1, 1);

    cur_req = "R11 page mode";
    st(0, 1, 1, 0); st(0, 0, 1, 0); st(0, 1, 0, 0); st(0, 0, 0, 0);
    chk("R11", int'(cyc_type), 3, "page early write");
    st(0, 1, 1, 0); st(0, 0, 1, 0);
    chk("R11", int'(cyc_type), 2, "page read");
    st(0, 1, 1, 0); st(1, 1, 1, 1);

    cur_req = "R5 R8 refresh";
    cbr(1'b1);
    chk("R5", int'(m_cnt), 1, "counter after cbr");
    cbr(1'b0);
    chk("R8", int'(tmode), 1, "wcbr enters test");
    cur_req = "R6 R8 hidden";
    addr = 10'd9;
    st(0, 1, 1, 0); st(0, 0, 1, 0); st(1, 0, 1, 0); st(0, 0, 1, 0);
    chk("R6", int'(cyc_type), 8, "hidden refresh");
    chk("R6", int'(ref_row), 2, "hidden uses counter");
    chk("R8", int'(tmode), 1, "hidden keeps test");
    chk("R9", int'(dq_oe), 1, "hidden keeps data");
    st(1, 0, 1, 0); st(1, 1, 1, 1);
    cbr(1'b1);
    chk("R8", int'(tmode), 0, "cbr leaves test");
    cbr(1'b0);

    cur_req = "R4 R8 ras only";
    addr = 10'h2A5;
    st(0, 1, 1, 1); addr = 10'h0; st(0, 1, 1, 1); st(1, 1, 1, 1);
    chk("R4", int'(cyc_type), 5, "ras only");
    chk("R4", int'(ref_row), 'h2A5, "ras only row");
    chk("R8", int'(tmode), 0, "ras only leaves test");

    cur_req = "R7 wrap";
    while (m_cnt != NROWS - 1) cbr(1'b1);
    st(1, 0, 1, 1); st(0, 0, 1, 1);
    chk("R7", int'(ref_row), NROWS - 1, "top row");
    st(1, 0, 1, 1); st(1, 1, 1, 1);
    cbr(1'b1);
    chk("R7", int'(ref_row), 0, "wrapped row");

    cur_req = "R10 illegal";
    chk("R10", int'(err), 0, "no error yet");
    st(0, 0, 1, 1);
    chk("R10", int'(cyc_type), 9, "simultaneous fall");
    st(1, 1, 1, 1); st(0, 1, 1, 0); st(0, 0, 1, 0); st(0, 1, 1, 0); st(1, 1, 1, 1);
    chk("R10", int'(err), 1, "error sticky");
    st(1, 0, 1, 1); st(0, 0, 1, 1); st(0, 1, 1, 1); st(0, 0, 1, 1);
    chk("R10", int'(cyc_type), 9, "column fall in refresh");
    st(1, 1, 1, 1); st(1, 1, 1, 1);
    chk("R10", int'(err), 1, "error still set");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule